// File: doc/BRIEF.md
# General-Purpose I/O Port Bank

A bank of bidirectional pins, grouped into 8-bit ports, that software controls through a small register bus. Each pin has an output latch and a direction bit of its own. Pull-up requests are made per group of four adjacent pins, and a pull-up reaches the pad only while that pad is not being driven. An on-chip peripheral can take over any pin's output through an alternate-function enable, whatever the pin's direction bit says. One pin is wired as input-only. One port has an extra register that requests high-current sink drive on its pads.

Reads of a port's data address return the synchronized pin level for input pins and the latch for output pins. A control bit can force reads to return the latch on every pin. When an external-bus mode input is high, the pull-ups of the groups that carry the bus are forced off.

Register map (4-bit address, 8-bit data): port p data at p, port p direction at 4+p, pull-up group bits at 8 (bit g covers pins 4g..4g+3), drive-strength bits at 9, control at 10 (bit 0 selects readback). Any other address reads 0 and ignores writes.

Top module: `gpio_bank`

## Requirements
- R1: While rst_n is low, and after it is released, pad_oe, pad_out, pad_pu and pad_hi_drive are all 0 and every register reads 0. Reset assertion clears the outputs at once, without waiting for a clock edge.
- R2: Bit i of a direction register (1 = output) drives pad_oe for pin 8p+i. It reads back unchanged.
- R3: Data written to a port's data address is held in its latch and appears on pad_out for that port's pins.
- R4: Pull-up group bit g (address 8) sets pad_pu on pins 4g..4g+3 only while pad_oe of that pin is 0.
- R5: When alt_oe[i] is 1, pad_oe[i] is 1 and pad_out[i] equals alt_out[i], whatever the direction bit of the pin.
- R6: The input-only pin (default pin 15) never has pad_oe or pad_pu set. Its direction bit reads 0 and writes to it are ignored.
- R7: With control bit 0 at 0, a data read returns the latch on pins whose direction bit is 1 and the synchronized pin level on the others. With the bit at 1, a data read returns the latch on every pin.
- R8: A change on pin_in first shows in a data read after the second rising clock edge that follows it, and not after the first.
- R9: While ext_bus_mode is 1, pad_pu is 0 on every pin of the groups selected by BUS_GRP_MASK (default groups 0 and 1, pins 0..7). Other groups are unaffected.
- R10: The drive register (address 9) appears on pad_hi_drive for the pins of port DRIVE_PORT (default 1). All other bits of pad_hi_drive are 0.
- R11: A write takes effect on the rising edge at which wr_en is sampled high. Writes and reads to unmapped addresses have no effect and return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| pin_in | input | 16 | Pad input levels |
| alt_oe | input | 16 | Peripheral output enable per pin |
| alt_out | input | 16 | Peripheral output value per pin |
| ext_bus_mode | input | 1 | External-bus mode, cancels bus-group pull-ups |
| pad_oe | output | 16 | Pad output enable |
| pad_out | output | 16 | Pad output value |
| pad_pu | output | 16 | Pad pull-up enable |
| pad_hi_drive | output | 16 | Pad high-current sink enable |

## Verification
The bench mixes directions within one port and flips the readback bit. A design that picked the read source per port, or ignored the control bit, would return wrong nibbles. It sets pull-up groups that hold both output pins and the input-only pin, with the bus mode both on and off. A pull-up left on a driven pad, on pin 15, or on a bus group shows up directly on pad_pu. A peripheral enable is placed on a pin whose direction bit is input, and on the input-only pin. A missed override, or a pin 15 that can drive, would show on pad_oe. The bench times a pin change edge by edge, so a missing or extra synchronizer stage is caught. Writes to unmapped addresses are followed by reads of real registers to catch aliasing.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int GRP_W  = 4;
  localparam logic [ADDR_W-1:0] A_DATA_BASE = 4'd0;
  localparam logic [ADDR_W-1:0] A_DIR_BASE  = 4'd4;
  localparam logic [ADDR_W-1:0] A_PULLUP    = 4'd8;
  localparam logic [ADDR_W-1:0] A_DRIVE     = 4'd9;
  localparam logic [ADDR_W-1:0] A_CTRL      = 4'd10;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end
  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, stable_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= d;
      stable_q <= meta_q;
    end
  end
  assign q = stable_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int IN_ONLY_PIN = 15,
  localparam int N  = NUM_PORTS * DATA_W,
  localparam int NG = N / GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N-1:0]      pin_sync,
  output logic [DATA_W-1:0] rdata,
  output logic [N-1:0]      latch_o,
  output logic [N-1:0]      dir_o,
  output logic [NG-1:0]     pu_grp_o,
  output logic [DATA_W-1:0] drv_o
);
  localparam logic [N-1:0] IN_MASK = N'(1) << IN_ONLY_PIN;

  logic [N-1:0]      latch_q, latch_d, dir_q, dir_d;
  logic [NG-1:0]     pu_q, pu_d;
  logic [DATA_W-1:0] drv_q, drv_d;
  logic              rbsel_q, rbsel_d;

  // next state: one port slice per data/direction address
  always_comb begin
    latch_d = latch_q;
    dir_d   = dir_q;
    pu_d    = pu_q;
    drv_d   = drv_q;
    rbsel_d = rbsel_q;
    if (wr_en) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (addr == A_DATA_BASE + ADDR_W'(p))
          latch_d[p*DATA_W +: DATA_W] = wdata;
        if (addr == A_DIR_BASE + ADDR_W'(p))
          dir_d[p*DATA_W +: DATA_W] = wdata & ~IN_MASK[p*DATA_W +: DATA_W];
      end
      if (addr == A_PULLUP) pu_d    = wdata[NG-1:0];
      if (addr == A_DRIVE)  drv_d   = wdata;
      if (addr == A_CTRL)   rbsel_d = wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
      pu_q    <= '0;
      drv_q   <= '0;
      rbsel_q <= 1'b0;
    end else if (wr_en) begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
      pu_q    <= pu_d;
      drv_q   <= drv_d;
      rbsel_q <= rbsel_d;
    end
  end

  // read path: latch where the pin is an output or readback is forced
  always_comb begin
    logic [DATA_W-1:0] use_latch;
    rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      use_latch = dir_q[p*DATA_W +: DATA_W] | {DATA_W{rbsel_q}};
      if (addr == A_DATA_BASE + ADDR_W'(p))
        rdata = (latch_q[p*DATA_W +: DATA_W] & use_latch) |
                (pin_sync[p*DATA_W +: DATA_W] & ~use_latch);
      if (addr == A_DIR_BASE + ADDR_W'(p))
        rdata = dir_q[p*DATA_W +: DATA_W];
    end
    if (addr == A_PULLUP) rdata = DATA_W'(pu_q);
    if (addr == A_DRIVE)  rdata = drv_q;
    if (addr == A_CTRL)   rdata = {{(DATA_W-1){1'b0}}, rbsel_q};
  end

  assign latch_o  = latch_q;
  assign dir_o    = dir_q;
  assign pu_grp_o = pu_q;
  assign drv_o    = drv_q;
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int N           = 16,
  parameter int IN_ONLY_PIN = 15,
  localparam int NG = N / GRP_W,
  parameter logic [NG-1:0] BUS_GRP_MASK = '0
) (
  input  logic [N-1:0]  latch,
  input  logic [N-1:0]  dir,
  input  logic [NG-1:0] pu_grp,
  input  logic [N-1:0]  alt_oe,
  input  logic [N-1:0]  alt_out,
  input  logic          ext_bus_mode,
  output logic [N-1:0]  pad_oe,
  output logic [N-1:0]  pad_out,
  output logic [N-1:0]  pad_pu
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    localparam int G = i / GRP_W;
    logic drive;
    logic pu_req;
    if (i == IN_ONLY_PIN) begin : g_in_only
      assign drive = 1'b0;
    end else begin : g_bidir
      assign drive = dir[i] | alt_oe[i];
    end
    assign pu_req     = pu_grp[G] & ~(ext_bus_mode & BUS_GRP_MASK[G]);
    assign pad_oe[i]  = drive;
    assign pad_out[i] = alt_oe[i] ? alt_out[i] : latch[i];
    assign pad_pu[i]  = pu_req & ~drive & (i != IN_ONLY_PIN);
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int IN_ONLY_PIN = NUM_PORTS * DATA_W - 1,
  parameter int DRIVE_PORT  = 1,
  parameter logic [NUM_PORTS*DATA_W/GRP_W-1:0] BUS_GRP_MASK = 'b0011
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  input  logic [NUM_PORTS*DATA_W-1:0]   pin_in,
  input  logic [NUM_PORTS*DATA_W-1:0]   alt_oe,
  input  logic [NUM_PORTS*DATA_W-1:0]   alt_out,
  input  logic                          ext_bus_mode,
  output logic [NUM_PORTS*DATA_W-1:0]   pad_oe,
  output logic [NUM_PORTS*DATA_W-1:0]   pad_out,
  output logic [NUM_PORTS*DATA_W-1:0]   pad_pu,
  output logic [NUM_PORTS*DATA_W-1:0]   pad_hi_drive
);
  localparam int N  = NUM_PORTS * DATA_W;
  localparam int NG = N / GRP_W;

  logic              rst_sync_n;
  logic [N-1:0]      pin_sync, latch, dir;
  logic [NG-1:0]     pu_grp;
  logic [DATA_W-1:0] drv;

  gpio_rst_sync u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n)
  );

  gpio_in_sync #(.W(N)) u_in_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(pin_in), .q(pin_sync)
  );

  gpio_regs #(.NUM_PORTS(NUM_PORTS), .IN_ONLY_PIN(IN_ONLY_PIN)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .pin_sync(pin_sync), .rdata(rdata),
    .latch_o(latch), .dir_o(dir), .pu_grp_o(pu_grp), .drv_o(drv)
  );

  gpio_pin_ctrl #(.N(N), .IN_ONLY_PIN(IN_ONLY_PIN),
                  .BUS_GRP_MASK(BUS_GRP_MASK)) u_pins (
    .latch(latch), .dir(dir), .pu_grp(pu_grp), .alt_oe(alt_oe),
    .alt_out(alt_out), .ext_bus_mode(ext_bus_mode),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  always_comb begin
    pad_hi_drive = '0;
    pad_hi_drive[DRIVE_PORT*DATA_W +: DATA_W] = drv;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int IN_ONLY_PIN = 15,
  localparam int N  = NUM_PORTS * DATA_W,
  localparam int NG = N / GRP_W,
  parameter logic [NG-1:0] BUS_GRP_MASK = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [N-1:0]      alt_oe,
  input logic [N-1:0]      alt_out,
  input logic              ext_bus_mode,
  input logic [N-1:0]      pad_oe,
  input logic [N-1:0]      pad_out,
  input logic [N-1:0]      pad_pu
);
  localparam logic [N-1:0] IN_MASK = N'(1) << IN_ONLY_PIN;

  function automatic logic [N-1:0] grp_to_pins(logic [NG-1:0] g);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = g[i / GRP_W];
    return m;
  endfunction
  localparam logic [N-1:0] BUS_PIN_MASK = grp_to_pins(BUS_GRP_MASK);

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIR_BASE) |=>
      ((pad_oe[DATA_W-1:0] & ~alt_oe[DATA_W-1:0] & ~IN_MASK[DATA_W-1:0]) ==
       ($past(wdata) & ~alt_oe[DATA_W-1:0] & ~IN_MASK[DATA_W-1:0])));

  // R4
  pullup_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  // R5
  alt_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((alt_oe & ~IN_MASK) & ~pad_oe) == '0) &&
    (((pad_out ^ alt_out) & alt_oe) == '0));

  // R6
  in_only_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe[IN_ONLY_PIN] && !pad_pu[IN_ONLY_PIN]);

  // R9
  bus_pullup_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_bus_mode |-> ((pad_pu & BUS_PIN_MASK) == '0));
endmodule

bind gpio_bank gpio_bank_chk #(
  .NUM_PORTS(NUM_PORTS), .IN_ONLY_PIN(IN_ONLY_PIN), .BUS_GRP_MASK(BUS_GRP_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .alt_oe(alt_oe), .alt_out(alt_out), .ext_bus_mode(ext_bus_mode),
  .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [15:0] pin_in, alt_oe, alt_out;
  logic        ext_bus_mode;
  logic [15:0] pad_oe, pad_out, pad_pu, pad_hi_drive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  gpio_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .alt_oe(alt_oe), .alt_out(alt_out),
    .ext_bus_mode(ext_bus_mode), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu), .pad_hi_drive(pad_hi_drive)
  );

  always #10 clk = ~clk;

  // entry: {req[3:0], write, addr[3:0], data_or_expected[7:0]}
  localparam int NT = 25;
  localparam logic [16:0] TBL [NT] = '{
    {4'd7,  1'b0, 4'd0,  8'hC3},  // R7 all inputs: pin level
    {4'd7,  1'b0, 4'd1,  8'hA5},  // R7
    {4'd3,  1'b1, 4'd0,  8'h3C},  // R3 latch port 0
    {4'd7,  1'b0, 4'd0,  8'hC3},  // R7 latch hidden while input
    {4'd2,  1'b1, 4'd4,  8'hF0},  // R2 upper nibble output
    {4'd7,  1'b0, 4'd0,  8'h33},  // R7 mixed source
    {4'd2,  1'b0, 4'd4,  8'hF0},  // R2 direction readback
    {4'd6,  1'b1, 4'd5,  8'hFF},  // R6 try to make pin 15 output
    {4'd6,  1'b0, 4'd5,  8'h7F},  // R6 pin 15 stays input
    {4'd3,  1'b1, 4'd1,  8'h00},  // R3
    {4'd7,  1'b0, 4'd1,  8'h80},  // R7 pin 15 reads pin level
    {4'd7,  1'b1, 4'd10, 8'h01},  // R7 force latch readback
    {4'd7,  1'b0, 4'd10, 8'h01},  // R7
    {4'd7,  1'b0, 4'd0,  8'h3C},  // R7
    {4'd7,  1'b0, 4'd1,  8'h00},  // R7
    {4'd7,  1'b1, 4'd10, 8'h00},  // R7
    {4'd10, 1'b1, 4'd9,  8'h5A},  // R10
    {4'd10, 1'b0, 4'd9,  8'h5A},  // R10
    {4'd4,  1'b1, 4'd8,  8'h0F},  // R4 all groups
    {4'd4,  1'b0, 4'd8,  8'h0F},  // R4
    {4'd11, 1'b0, 4'd2,  8'h00},  // R11 unmapped data address
    {4'd11, 1'b1, 4'd12, 8'hFF},  // R11 unmapped write
    {4'd11, 1'b0, 4'd12, 8'h00},  // R11
    {4'd11, 1'b0, 4'd0,  8'h33},  // R11 no aliasing
    {4'd11, 1'b0, 4'd4,  8'hF0}   // R11
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input string req, input logic [3:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    check(req, {8'h00, rdata}, {8'h00, exp});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    pin_in = 16'hA5C3; alt_oe = '0; alt_out = '0; ext_bus_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    check("R1", pad_oe | pad_out | pad_pu | pad_hi_drive, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", pad_oe | pad_out | pad_pu | pad_hi_drive, 16'h0000);
    bus_read("R1", 4'd4, 8'h00);

    for (int k = 0; k < NT; k++) begin
      string tag;
      tag = $sformatf("R%0d(entry %0d)", TBL[k][16:13], k);
      if (TBL[k][12]) bus_write(TBL[k][11:8], TBL[k][7:0]);
      else            bus_read(tag, TBL[k][11:8], TBL[k][7:0]);
    end

    // pad view of the table's final state
    check("R2", pad_oe, 16'h7FF0);
    check("R3", pad_out, 16'h003C);
    check("R4/R6 pull-ups", pad_pu, 16'h000F);
    check("R10", pad_hi_drive, 16'h5A00);

    // R9 bus mode cancels groups 0 and 1
    ext_bus_mode = 1'b1; #1;
    check("R9", pad_pu, 16'h0000);
    bus_write(4'd5, 8'h00);
    check("R9 other groups kept", pad_pu, 16'h7F00);
    ext_bus_mode = 1'b0; #1;
    check("R4", pad_pu, 16'h7F0F);

    // R5 peripheral override on an input pin, and on pin 15 (R6)
    alt_oe = 16'h8001; alt_out = 16'h0001; #1;
    check("R5 oe", pad_oe, 16'h00F1);
    check("R5 out", pad_out, 16'h003D);
    check("R4 driven pad no pull-up", pad_pu, 16'h7F0E);
    alt_oe = '0; alt_out = '0;
    @(negedge clk);

    // R11 write lands on the edge
    wr_en = 1'b1; addr = 4'd4; wdata = 8'h0F; #1;
    check("R11 before edge", pad_oe, 16'h00F0);
    @(posedge clk); #1;
    check("R11 after edge", pad_oe, 16'h000F);
    @(negedge clk); wr_en = 1'b0;

    // R8 two-stage input synchronizer
    bus_read("R8 base", 4'd0, 8'hCC);
    pin_in = 16'hA543;
    @(negedge clk);
    bus_read("R8 one edge", 4'd0, 8'hCC);
    @(negedge clk);
    bus_read("R8 two edges", 4'd0, 8'h4C);

    // R1 asynchronous reset mid-run
    rst_n = 1'b0; #1;
    check("R1 async", pad_oe | pad_pu | pad_hi_drive | pad_out, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read("R1", 4'd8, 8'h00);
    bus_read("R1", 4'd10, 8'h00);
    bus_read("R1", 4'd9, 8'h00);

    finish_run();
  end
endmodule